// File: doc/BRIEF.md
# Line-Code Receive System Interface

This block sits behind a receive front end that has already recovered timing and sliced the line signal into two rail pulses, positive and negative. It removes the line coding and hands received data to the system side. Plain alternate mark inversion decoding is always available. A substitution decoder can be switched in as well. It restores eight zeros from the T1/J1 substitution pattern, or four zeros from the two E1 substitution patterns. The choice between the T1/J1 and E1 patterns follows a single select input.

The block runs from a clock at twice the line bit rate, so 4.096 MHz for E1 and 3.088 MHz for T1/J1. It derives from that clock a receive clock at the nominal bit rate. Received data goes out in one of two formats. In single-rail format, one output carries the data and the other flags code violations. In dual-rail format, the decoded positive and negative pulses appear on the two outputs. The data outputs can change on either edge of the receive clock, and their polarity can be inverted. A bypass mode passes the raw rails straight through and drives the exclusive OR of the rails as the clock. A power-off input holds every output low.

Top module: `rx_line_sysif`

## Requirements
- R1: While rst_ni is low, and before the first clock edge after its release, rclk_o, rd_o, rdn_o and los_o are all low.
- R2: In every mode other than bypass, rclk_o reads 1 after odd-numbered clk_i edges and 0 after even-numbered ones, counting from the release of reset. The rails are sampled only at odd-numbered edges, so bit k is taken at edge 2k+1.
- R3: With fall_edge_i at 0, the outputs for bit k appear at edge 2k+17, and the data outputs change only at edges where rclk_o rises. With fall_edge_i at 1, they appear at edge 2k+16, and change only where rclk_o falls. The data registers reset to 0. Before bit 0 reaches them, they take the value data_inv_i, starting from the first update edge of the selected kind (edge 1 or edge 2).
- R4: The rx_mode_i encoding is: 00 single-rail with substitution decoding, 01 single-rail plain AMI, 10 dual-rail with substitution decoding, 11 bypass.
- R5: A mark is a pulse on either rail, and its polarity is positive when rail_pos_i is high. In single-rail mode, rd_o is 1 for a mark. rdn_o is 1 for a mark whose polarity equals that of the previous mark. The first mark after reset is never flagged.
- R6: With e1_sel_i at 0 and substitution decoding enabled, the sequence zero, zero, zero, violation, valid mark, zero, violation, valid mark decodes as eight zeros and raises no violation flag.
- R7: With e1_sel_i at 1 and substitution decoding enabled, a violation preceded by three zeros decodes as four zeros. A violation preceded by a valid mark and then two zeros also decodes as four zeros. Neither is flagged. A violation that fits neither pattern is still flagged.
- R8: In dual-rail mode, rd_o carries decoded positive pulses and rdn_o carries decoded negative pulses, with substitutions removed.
- R9: In bypass mode, rd_o and rdn_o equal rail_pos_i and rail_neg_i from the previous clk_i edge, and rclk_o equals the XOR of those same two rail values.
- R10: When data_inv_i is 1, rd_o and rdn_o (the violation flag included) show the complement of their normal values. rclk_o and los_o are not affected.
- R11: While rx_off_i is high, rclk_o, rd_o, rdn_o and los_o are all low.
- R12: When rx_off_i is low, los_o equals the value los_i had at the previous clk_i edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the line bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e1_sel_i | input | 1 | 1 selects the E1 substitution decoder, 0 selects T1/J1 |
| rx_mode_i | input | 2 | Decode and format mode (R4) |
| fall_edge_i | input | 1 | 1 makes the falling edge of rclk_o the data update edge |
| data_inv_i | input | 1 | Inverts the data outputs |
| rx_off_i | input | 1 | Receive power off: forces all outputs low |
| rail_pos_i | input | 1 | Positive rail pulse from the front end |
| rail_neg_i | input | 1 | Negative rail pulse from the front end |
| los_i | input | 1 | Loss indication from the front end |
| rclk_o | output | 1 | Receive clock |
| rd_o | output | 1 | Data (single-rail) or positive data (dual-rail, bypass) |
| rdn_o | output | 1 | Violation flag (single-rail) or negative data |
| los_o | output | 1 | Registered loss indication |

## Verification
The checker watches several behaviours on every cycle. It confirms that rclk_o toggles on each edge outside bypass and that power-off forces all four outputs low. It checks the one-edge pass-through of the rails, and of their XOR, in bypass mode, as well as the one-edge delay on the loss indication. It also confirms that the data outputs change only on the selected edge of rclk_o. Other behaviours can only be shown by the bench's scenarios, which compare each output against a model built from the rail patterns: the 16- or 15-edge decode latency, violation flagging, and the removal of the B8ZS and HDB3 substitutions, including stray violations placed next to valid patterns.

// File: rtl/rx_sysif_pkg.sv
package rx_sysif_pkg;
  typedef enum logic [1:0] {
    RXM_SUB_SR = 2'b00,
    RXM_AMI_SR = 2'b01,
    RXM_SUB_DR = 2'b10,
    RXM_BYPASS = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic pos;
    logic neg;
    logic cv;
  } rx_sym_t;

  localparam int unsigned MIN_DEPTH = 8;
endpackage

// File: rtl/rx_bit_phase.sv
module rx_bit_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph_o,
  output logic adv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_o <= 1'b0;
    else         ph_o <= ~ph_o;
  end

  // a bit is taken on the edge where the receive clock rises
  assign adv_o = ~ph_o;
endmodule

// File: rtl/rx_line_decoder.sv
module rx_line_decoder
  import rx_sysif_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    adv_i,
  input  logic    e1_i,
  input  logic    sub_en_i,
  input  logic    pos_i,
  input  logic    neg_i,
  output rx_sym_t tail_o
);
  localparam int unsigned WIN = (DEPTH < MIN_DEPTH) ? MIN_DEPTH : DEPTH;

  rx_sym_t          stg_q [WIN];
  rx_sym_t          win   [WIN];
  rx_sym_t          in_sym;
  logic [WIN-1:0]   mk, vl, clr;
  logic             last_pos_q, seen_q;
  logic             b8zs_hit, hdb3_hit;

  always_comb begin
    in_sym.pos = pos_i;
    in_sym.neg = neg_i & ~pos_i;
    in_sym.cv  = (pos_i | neg_i) & seen_q & (pos_i == last_pos_q);
  end

  assign win[0] = in_sym;
  assign mk[0]  = in_sym.pos | in_sym.neg;
  assign vl[0]  = in_sym.cv;

  for (genvar i = 1; i < WIN; i++) begin : g_win
    assign win[i] = stg_q[i-1];
    assign mk[i]  = stg_q[i-1].pos | stg_q[i-1].neg;
    assign vl[i]  = stg_q[i-1].cv;
  end

  // index 0 is the newest bit; patterns read oldest to newest from the top
  always_comb begin
    b8zs_hit = sub_en_i & ~e1_i & ~mk[7] & ~mk[6] & ~mk[5] & mk[4] & vl[4] &
               mk[3] & ~vl[3] & ~mk[2] & mk[1] & vl[1] & mk[0] & ~vl[0];
    hdb3_hit = sub_en_i & e1_i & mk[0] & vl[0] & ~mk[1] & ~mk[2] &
               ~(mk[3] & vl[3]);
    clr      = '0;
    if (b8zs_hit) begin
      clr[4] = 1'b1;
      clr[3] = 1'b1;
      clr[1] = 1'b1;
      clr[0] = 1'b1;
    end
    if (hdb3_hit) begin
      clr[3] = 1'b1;
      clr[0] = 1'b1;
    end
  end

  for (genvar i = 0; i < WIN; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stg_q[i] <= '0;
      else if (adv_i) stg_q[i] <= clr[i] ? '0 : win[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pos_q <= 1'b0;
      seen_q     <= 1'b0;
    end else if (adv_i && mk[0]) begin
      last_pos_q <= in_sym.pos;
      seen_q     <= 1'b1;
    end
  end

  assign tail_o = stg_q[WIN-1];
endmodule

// File: rtl/rx_out_format.sv
module rx_out_format
  import rx_sysif_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rx_mode_e mode_i,
  input  logic     fall_sel_i,
  input  logic     inv_i,
  input  logic     off_i,
  input  logic     ph_i,
  input  rx_sym_t  tail_i,
  input  logic     raw_pos_i,
  input  logic     raw_neg_i,
  input  logic     los_i,
  output logic     rclk_o,
  output logic     da_o,
  output logic     db_o,
  output logic     los_o
);
  logic da_q, db_q, xclk_q, los_q;
  logic bypass, dual, upd;

  assign bypass = (mode_i == RXM_BYPASS);
  assign dual   = mode_i[1];
  assign upd    = fall_sel_i ? ph_i : ~ph_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      da_q   <= 1'b0;
      db_q   <= 1'b0;
      xclk_q <= 1'b0;
      los_q  <= 1'b0;
    end else begin
      los_q  <= los_i;
      xclk_q <= raw_pos_i ^ raw_neg_i;
      if (bypass) begin
        da_q <= raw_pos_i ^ inv_i;
        db_q <= raw_neg_i ^ inv_i;
      end else if (upd) begin
        da_q <= (dual ? tail_i.pos : (tail_i.pos | tail_i.neg)) ^ inv_i;
        db_q <= (dual ? tail_i.neg : tail_i.cv) ^ inv_i;
      end
    end
  end

  assign rclk_o = (bypass ? xclk_q : ph_i) & ~off_i;
  assign da_o   = da_q  & ~off_i;
  assign db_o   = db_q  & ~off_i;
  assign los_o  = los_q & ~off_i;
endmodule

// File: rtl/rx_line_sysif.sv
module rx_line_sysif
  import rx_sysif_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       e1_sel_i,
  input  logic [1:0] rx_mode_i,
  input  logic       fall_edge_i,
  input  logic       data_inv_i,
  input  logic       rx_off_i,
  input  logic       rail_pos_i,
  input  logic       rail_neg_i,
  input  logic       los_i,
  output logic       rclk_o,
  output logic       rd_o,
  output logic       rdn_o,
  output logic       los_o
);
  rx_mode_e mode;
  rx_sym_t  tail;
  logic     ph, adv;

  assign mode = rx_mode_e'(rx_mode_i);

  rx_bit_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph_o  (ph),
    .adv_o (adv)
  );

  rx_line_decoder #(.DEPTH(DEPTH)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .e1_i    (e1_sel_i),
    .sub_en_i(~rx_mode_i[0]),
    .pos_i   (rail_pos_i),
    .neg_i   (rail_neg_i),
    .tail_o  (tail)
  );

  rx_out_format u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .fall_sel_i(fall_edge_i),
    .inv_i     (data_inv_i),
    .off_i     (rx_off_i),
    .ph_i      (ph),
    .tail_i    (tail),
    .raw_pos_i (rail_pos_i),
    .raw_neg_i (rail_neg_i),
    .los_i     (los_i),
    .rclk_o    (rclk_o),
    .da_o      (rd_o),
    .db_o      (rdn_o),
    .los_o     (los_o)
  );
endmodule

// File: rtl/rx_line_sysif_chk.sv
module rx_line_sysif_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] rx_mode_i,
  input logic       fall_edge_i,
  input logic       data_inv_i,
  input logic       rx_off_i,
  input logic       rail_pos_i,
  input logic       rail_neg_i,
  input logic       los_i,
  input logic       rclk_o,
  input logic       rd_o,
  input logic       rdn_o,
  input logic       los_o
);
  a_r11_power_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_off_i |-> (!rclk_o && !rd_o && !rdn_o && !los_o));

  a_r2_rclk_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && rx_mode_i != 2'b11 && $past(rx_mode_i) != 2'b11 &&
     !rx_off_i && !$past(rx_off_i)) |-> (rclk_o != $past(rclk_o)));

  a_r9_bypass_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && rx_mode_i == 2'b11 && $past(rx_mode_i) == 2'b11 &&
     !rx_off_i && $stable(data_inv_i)) |->
    (rd_o == ($past(rail_pos_i) ^ data_inv_i) &&
     rdn_o == ($past(rail_neg_i) ^ data_inv_i) &&
     rclk_o == ($past(rail_pos_i) ^ $past(rail_neg_i))));

  a_r12_los_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !rx_off_i) |-> (los_o == $past(los_i)));

  a_r3_update_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && rx_mode_i != 2'b11 && $stable(rx_mode_i) &&
     $stable(fall_edge_i) && $stable(data_inv_i) && !rx_off_i &&
     !$past(rx_off_i) && (rd_o != $past(rd_o) || rdn_o != $past(rdn_o))) |->
    (fall_edge_i ? $fell(rclk_o) : $rose(rclk_o)));
endmodule

bind rx_line_sysif rx_line_sysif_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_mode_i  (rx_mode_i),
  .fall_edge_i(fall_edge_i),
  .data_inv_i (data_inv_i),
  .rx_off_i   (rx_off_i),
  .rail_pos_i (rail_pos_i),
  .rail_neg_i (rail_neg_i),
  .los_i      (los_i),
  .rclk_o     (rclk_o),
  .rd_o       (rd_o),
  .rdn_o      (rdn_o),
  .los_o      (los_o)
);

// File: tb/tb_rx_line_sysif.sv
module tb_rx_line_sysif;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       e1 = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       fsel = 1'b0, inv = 1'b0, off = 1'b0;
  logic       rp = 1'b0, rn = 1'b0, los = 1'b0;
  logic       rclk_o, rd_o, rdn_o, los_o;

  always #4 clk = ~clk;

  rx_line_sysif dut (
    .clk_i(clk), .rst_ni(rst_ni), .e1_sel_i(e1), .rx_mode_i(mode),
    .fall_edge_i(fsel), .data_inv_i(inv), .rx_off_i(off),
    .rail_pos_i(rp), .rail_neg_i(rn), .los_i(los),
    .rclk_o(rclk_o), .rd_o(rd_o), .rdn_o(rdn_o), .los_o(los_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int sp[128], sn[128], mm[128], pp[128], vv[128], ea[128], eb[128];
  int nbits;

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int mk(int i);
    return (i < 0) ? 0 : mm[i];
  endfunction
  function automatic int vk(int i);
    return (i < 0) ? 0 : vv[i];
  endfunction

  task automatic load(string s);
    nbits = s.len() + 24;
    for (int i = 0; i < 128; i++) begin sp[i] = 0; sn[i] = 0; end
    for (int i = 0; i < s.len(); i++) begin
      sp[i] = (s[i] == "+") ? 1 : 0;
      sn[i] = (s[i] == "-") ? 1 : 0;
    end
  endtask

  // reference: flag repeated polarity, then erase recognised substitutions
  task automatic model(bit sub, bit e1m, bit dual);
    int seen = 0, lp = 0;
    for (int k = 0; k < 128; k++) begin
      mm[k] = sp[k] | sn[k];
      pp[k] = sp[k];
      vv[k] = 0;
      if (mm[k] != 0) begin
        if (seen != 0 && pp[k] == lp) vv[k] = 1;
        seen = 1;
        lp = pp[k];
      end
    end
    if (sub) begin
      for (int k = 0; k < 128; k++) begin
        if (!e1m) begin
          if (mk(k-7) == 0 && mk(k-6) == 0 && mk(k-5) == 0 && mk(k-4) == 1 && vk(k-4) == 1 &&
              mk(k-3) == 1 && vk(k-3) == 0 && mk(k-2) == 0 && mk(k-1) == 1 && vk(k-1) == 1 &&
              mk(k) == 1 && vk(k) == 0) begin
            mm[k-4] = 0; vv[k-4] = 0; mm[k-3] = 0; vv[k-3] = 0;
            mm[k-1] = 0; vv[k-1] = 0; mm[k] = 0; vv[k] = 0;
          end
        end else begin
          if (mk(k) == 1 && vk(k) == 1 && mk(k-1) == 0 && mk(k-2) == 0 &&
              !(mk(k-3) == 1 && vk(k-3) == 1)) begin
            mm[k] = 0; vv[k] = 0;
            if (k >= 3) begin mm[k-3] = 0; vv[k-3] = 0; end
          end
        end
      end
    end
    for (int k = 0; k < 128; k++) begin
      ea[k] = dual ? (mm[k] & pp[k]) : mm[k];
      eb[k] = dual ? (mm[k] & (1 - pp[k])) : vv[k];
    end
  endtask

  task automatic do_reset(bit e1v, logic [1:0] mv, bit fv, bit iv);
    @(negedge clk);
    rst_ni = 1'b0; rp = 0; rn = 0; los = 0; off = 0;
    e1 = e1v; mode = mv; fsel = fv; inv = iv;
    repeat (2) @(negedge clk);
    chk("R1", "rclk in reset", rclk_o, 1'b0);
    chk("R1", "rd in reset", rd_o, 1'b0);
    chk("R1", "rdn in reset", rdn_o, 1'b0);
    chk("R1", "los in reset", los_o, 1'b0);
    rst_ni = 1'b1;
    #1;
    chk("R1", "rd after release", rd_o, 1'b0);
    chk("R1", "rclk after release", rclk_o, 1'b0);
  endtask

  task automatic run_dec(string req, int nedges, int off_from, int off_to);
    int e = 0;
    logic lcur, ocur, xa, xb;
    while (e < nedges) begin
      int up = e + 1;
      if (up % 2 == 1) begin rp = sp[(up-1)/2][0]; rn = sn[(up-1)/2][0]; end
      los = ((up * 5) % 7) < 3;
      off = (up >= off_from && up < off_to);
      lcur = los; ocur = off;
      @(posedge clk);
      e++;
      @(negedge clk);
      if (!fsel) begin
        if (e < 1) begin xa = 0; xb = 0; end
        else if (e < 17) begin xa = inv; xb = inv; end
        else begin xa = ea[(e-17)/2][0] ^ inv; xb = eb[(e-17)/2][0] ^ inv; end
      end else begin
        if (e < 2) begin xa = 0; xb = 0; end
        else if (e < 16) begin xa = inv; xb = inv; end
        else begin xa = ea[(e-16)/2][0] ^ inv; xb = eb[(e-16)/2][0] ^ inv; end
      end
      if (ocur) begin
        chk("R11", "rclk off", rclk_o, 1'b0);
        chk("R11", "rd off", rd_o, 1'b0);
        chk("R11", "rdn off", rdn_o, 1'b0);
        chk("R11", "los off", los_o, 1'b0);
      end else begin
        chk("R2", "rclk phase", rclk_o, logic'(e % 2));
        chk(req, "rd", rd_o, xa);
        chk(req, "rdn", rdn_o, xb);
        chk("R12", "los", los_o, lcur);
      end
    end
    off = 0;
  endtask

  task automatic run_bypass(int nedges);
    logic pc, nc, lc;
    for (int e = 1; e <= nedges; e++) begin
      rp = ((e * 3) % 5) < 2;
      rn = ((e * 7) % 4) == 1;
      los = ((e * 5) % 7) < 3;
      pc = rp; nc = rn; lc = los;
      @(posedge clk);
      @(negedge clk);
      chk("R9", "bypass rd", rd_o, pc ^ inv);
      chk("R9", "bypass rdn", rdn_o, nc ^ inv);
      chk("R9", "bypass rclk", rclk_o, pc ^ nc);
      chk("R12", "bypass los", los_o, lc);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    string pa, pb, ph;
    pa = "++0-0-+-00+0+--+";
    pb = "+-000-+0+-+-0--0+";
    ph = "+000+-00-+0-0-+";

    // R5 R4: plain AMI single rail, rising edge
    load(pa); model(1'b0, 1'b0, 1'b0);
    do_reset(1'b0, 2'b01, 1'b0, 1'b0);
    run_dec("R5", 2 * pa.len() + 30, 1000, 1000);

    // R6: T1 substitution single rail
    load(pb); model(1'b1, 1'b0, 1'b0);
    do_reset(1'b0, 2'b00, 1'b0, 1'b0);
    run_dec("R6", 2 * pb.len() + 30, 1000, 1000);

    // R7 R3 R10: E1 substitution, falling edge, inverted
    load(ph); model(1'b1, 1'b1, 1'b0);
    do_reset(1'b1, 2'b00, 1'b1, 1'b1);
    run_dec("R7", 2 * ph.len() + 30, 1000, 1000);

    // R8: E1 dual rail
    load(ph); model(1'b1, 1'b1, 1'b1);
    do_reset(1'b1, 2'b10, 1'b0, 1'b0);
    run_dec("R8", 2 * ph.len() + 30, 1000, 1000);

    // R8 R3: T1 dual rail, falling edge
    load(pb); model(1'b1, 1'b0, 1'b1);
    do_reset(1'b0, 2'b10, 1'b1, 1'b0);
    run_dec("R8", 2 * pb.len() + 30, 1000, 1000);

    // R10 R5: inverted AMI, violation flag inverted too
    load(pa); model(1'b0, 1'b0, 1'b0);
    do_reset(1'b0, 2'b01, 1'b0, 1'b1);
    run_dec("R10", 2 * pa.len() + 30, 1000, 1000);

    // R11: power off window mid-stream
    load(pb); model(1'b1, 1'b0, 1'b0);
    do_reset(1'b0, 2'b00, 1'b0, 1'b0);
    run_dec("R11", 2 * pb.len() + 30, 20, 31);

    // R9 R10: bypass, plain then inverted
    do_reset(1'b0, 2'b11, 1'b0, 1'b0);
    run_bypass(24);
    do_reset(1'b1, 2'b11, 1'b1, 1'b1);
    run_bypass(24);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule